// File: doc/BRIEF.md
# Multi-part SMBus request reassembler

This block sits on the write side of a management message interface that is reached over SMBus. The bus front end hands it each block-write as a start marker, a run of valid bytes and a stop marker. The first byte is a command code, the second a byte count and the rest is payload. At the stop the block judges the whole write. An accepted write either starts a request, adds a fragment to the request being built, or completes it, all inside a 255-byte message store.

When a request is complete, the block drops outgoing response state and, for an ordinary request, gives a one-cycle ready pulse with the message length. The consumer then reads the message through a random-access read port. One request, the interface-capability query, is never handed on: the block builds its reply itself and shows it on a small response read port. A rejected write gives a one-cycle error pulse and leaves the stored message as it was. For the two cycles in which a finished write is being judged and delivered, a busy flag is high and the bus side is ignored.

Top module: `ssif_req_assembler`

## Requirements
- R1: A write with code 0x02 and a valid frame of at least 2 payload bytes is a complete request: three cycles after the stop is sampled, `msg_ready` is high for exactly one cycle with `msg_len` equal to the payload count, and `msg_rdata` at address i gives payload byte i.
- R2: The second byte of a write that holds at least two bytes must equal the number of bytes after it and must be at most 32; otherwise the write is rejected, whatever its code.
- R3: A write with code 0x02 or 0x06 (start of a multi-part request) with fewer than 2 payload bytes is rejected; an accepted one places its payload from offset 0 and sets the held length to its payload count.
- R4: A write with code 0x07 (middle fragment) or 0x08 (final fragment) while the held length is 0 is rejected.
- R5: If a 0x07 or 0x08 fragment would bring the held length past 255, the write is rejected and the held length becomes 0, so a following fragment is also rejected; a total of exactly 255 is accepted.
- R6: An accepted 0x07 fragment with fewer than 32 payload bytes (zero included, written as the code byte alone) completes the request, as does any accepted 0x08 fragment; a 0x07 fragment of exactly 32 bytes does not.
- R7: A completed request whose bytes 0 and 1 are 0x18 and 0x57 gives no `msg_ready`; instead `rsp_len` becomes 3 with byte 2 = 0xC7 if the request is shorter than 3 bytes, 3 with byte 2 = 0xCC if the low nibble of byte 2 is nonzero, and otherwise 7 with bytes 0x1C, 0x57, 0x00, 0x00, 0x80, 0xFF, 0xFF on `rsp_rdata` at addresses 0 to 6.
- R8: Every completed request pulses `rsp_clear` for one cycle together with the result; an ordinary request sets `rsp_len` to 0.
- R9: A rejected write pulses `err_pulse` for one cycle two cycles after the stop is sampled and leaves the stored message bytes unchanged.
- R10: `busy` is high for the two cycles after the stop is sampled when the request completes, and for one cycle otherwise; a start, bytes or a stop seen while `busy` is high are ignored.
- R11: Any other code with a valid frame, and a write of the code byte alone with such a code, has no effect: no error, no pulse and no change to the stored message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | Start of a block-write |
| bus_valid | input | 1 | `bus_data` holds the next byte of the write |
| bus_data | input | 8 | Write byte |
| bus_stop | input | 1 | End of the block-write |
| busy | output | 1 | Write being judged or delivered; bus side ignored |
| err_pulse | output | 1 | One-cycle pulse for a rejected write |
| msg_ready | output | 1 | One-cycle pulse for a completed ordinary request |
| msg_len | output | 8 | Length of the delivered request |
| msg_raddr | input | 8 | Message store read address |
| msg_rdata | output | 8 | Message store read data |
| rsp_clear | output | 1 | One-cycle pulse: outgoing read position and block index restart |
| rsp_len | output | 3 | Length of the locally built reply (0, 3 or 7) |
| rsp_raddr | input | 3 | Reply read address |
| rsp_rdata | output | 8 | Reply read data |

## Verification
On every cycle the assertions check that a write ends in at most one of error and ready, that each pulse lasts one cycle and follows a busy cycle, that a delivered ordinary request carries a cleared reply, that a discard empties the held length while a plain rejection keeps it, and that the reply length is one of its three legal values. Whether the frame rules, the exact 255-byte boundary, the short-middle completion, the reply bytes and the untouched store after a rejection are right can only be shown by the bench scenarios, which compare the ports against a behavioural model on every clock and read back the store and the reply.

// File: rtl/ssif_pkg.sv
package ssif_pkg;

  typedef enum logic [1:0] {
    AS_IDLE  = 2'd0,
    AS_RX    = 2'd1,
    AS_EVAL  = 2'd2,
    AS_DELIV = 2'd3
  } asm_state_t;

  // Command codes (behavioural: the host chooses them)
  localparam logic [7:0] OP_WHOLE = 8'h02;
  localparam logic [7:0] OP_FIRST = 8'h06;
  localparam logic [7:0] OP_MID   = 8'h07;
  localparam logic [7:0] OP_LAST  = 8'h08;

  // Capability query match and reply codes
  localparam logic [7:0] QRY_B0    = 8'h18;
  localparam logic [7:0] QRY_B1    = 8'h57;
  localparam logic [7:0] RPL_B0    = 8'h1C;
  localparam logic [7:0] CC_SHORT  = 8'hC7;
  localparam logic [7:0] CC_BADFLD = 8'hCC;
  localparam logic [7:0] RPL_MULTI = 8'h80;

  // Frame check: count field matches following bytes and fits a chunk
  function automatic logic frame_bad(input int nbytes, input logic [7:0] cnt_field,
                                     input int chunk);
    if (nbytes < 2) return 1'b0;
    return (int'(cnt_field) != nbytes - 2) || (int'(cnt_field) > chunk);
  endfunction

  // Reply byte at position idx of the locally built capability answer
  function automatic logic [7:0] cap_byte(input logic [2:0] idx, input logic [7:0] cc,
                                          input logic [7:0] max_len);
    case (idx)
      3'd0:    return RPL_B0;
      3'd1:    return QRY_B1;
      3'd2:    return cc;
      3'd4:    return RPL_MULTI;
      3'd5:    return max_len;
      3'd6:    return max_len;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/ssif_rx_framer.sv
module ssif_rx_framer #(
  parameter int CHUNK = 32,
  parameter int CW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             take,
  input  logic [7:0]       din,
  output logic [7:0]       cmd,
  output logic [7:0]       cnt_field,
  output logic [CW-1:0]    nbytes,
  output logic [7:0]       stage [CHUNK]
);
  localparam int CMAX = CHUNK + 3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nbytes    <= '0;
      cmd       <= '0;
      cnt_field <= '0;
    end else if (restart) begin
      nbytes    <= '0;
      cmd       <= '0;
      cnt_field <= '0;
    end else if (take) begin
      if (nbytes == CW'(0)) cmd <= din;
      if (nbytes == CW'(1)) cnt_field <= din;
      if (nbytes != CW'(CMAX)) nbytes <= nbytes + CW'(1);
    end
  end

  // One payload slot per chunk position
  for (genvar g = 0; g < CHUNK; g++) begin : g_slot
    logic [7:0] slot;
    always_ff @(posedge clk) begin
      if (take && nbytes == CW'(g + 2)) slot <= din;
    end
    assign stage[g] = slot;
  end

endmodule

// File: rtl/ssif_frag_judge.sv
module ssif_frag_judge
  import ssif_pkg::*;
#(
  parameter int MSG_MAX = 255,
  parameter int CHUNK   = 32,
  parameter int LW      = 8,
  parameter int CW      = 6
) (
  input  logic [7:0]    cmd,
  input  logic [7:0]    cnt_field,
  input  logic [CW-1:0] nbytes,
  input  logic [LW-1:0] held_len,
  output logic [CW-1:0] plen,
  output logic          reject,
  output logic          discard,
  output logic          commit,
  output logic          deliver,
  output logic [LW-1:0] base,
  output logic [LW-1:0] new_len
);
  logic bad_frame;
  logic too_long;
  int   sum;

  always_comb begin
    bad_frame = frame_bad(int'(nbytes), cnt_field, CHUNK);
    plen      = (nbytes >= CW'(2)) ? nbytes - CW'(2) : '0;
    sum       = int'(held_len) + int'(plen);
    too_long  = sum > MSG_MAX;
    reject    = 1'b0;
    discard   = 1'b0;
    commit    = 1'b0;
    deliver   = 1'b0;
    base      = '0;
    new_len   = LW'(plen);
    case (cmd)
      OP_WHOLE, OP_FIRST: begin
        reject  = bad_frame || (int'(plen) < 2);
        commit  = !reject;
        deliver = !reject && (cmd == OP_WHOLE);
      end
      OP_MID, OP_LAST: begin
        reject  = bad_frame || (held_len == '0) || too_long;
        discard = !bad_frame && (held_len != '0) && too_long;
        commit  = !reject;
        base    = held_len;
        new_len = LW'(sum);
        deliver = !reject && ((cmd == OP_LAST) || (int'(plen) < CHUNK));
      end
      default: reject = bad_frame;
    endcase
  end

  // Guards on the decision (R5, R6)
  always_comb begin
    if (discard) p_discard_rejects_r5 : assert (reject && !commit);
    if (deliver) p_deliver_commits_r6 : assert (commit);
  end

endmodule

// File: rtl/ssif_cap_responder.sv
module ssif_cap_responder
  import ssif_pkg::*;
#(
  parameter int MSG_MAX = 255
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       is_query,
  input  logic       too_short,
  input  logic       bad_field,
  input  logic [2:0] rsp_raddr,
  output logic       rsp_clear,
  output logic [2:0] rsp_len,
  output logic [7:0] rsp_rdata
);
  logic [7:0] cc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_clear <= 1'b0;
      rsp_len   <= '0;
      cc        <= '0;
    end else begin
      rsp_clear <= fire;
      if (fire) begin
        if (!is_query) begin
          rsp_len <= 3'd0;
        end else if (too_short) begin
          rsp_len <= 3'd3;
          cc      <= CC_SHORT;
        end else if (bad_field) begin
          rsp_len <= 3'd3;
          cc      <= CC_BADFLD;
        end else begin
          rsp_len <= 3'd7;
          cc      <= 8'h00;
        end
      end
    end
  end

  assign rsp_rdata = (rsp_raddr < rsp_len) ? cap_byte(rsp_raddr, cc, 8'(MSG_MAX)) : 8'h00;

  p_rsp_len_legal_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_len == 3'd0) || (rsp_len == 3'd3) || (rsp_len == 3'd7));

  p_clear_one_cycle_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    rsp_clear |=> !rsp_clear);

endmodule

// File: rtl/ssif_req_assembler.sv
module ssif_req_assembler
  import ssif_pkg::*;
#(
  parameter int MSG_MAX = 255,
  parameter int CHUNK   = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_start,
  input  logic                            bus_valid,
  input  logic [7:0]                      bus_data,
  input  logic                            bus_stop,
  output logic                            busy,
  output logic                            err_pulse,
  output logic                            msg_ready,
  output logic [$clog2(MSG_MAX + 1)-1:0]  msg_len,
  input  logic [$clog2(MSG_MAX + 1)-1:0]  msg_raddr,
  output logic [7:0]                      msg_rdata,
  output logic                            rsp_clear,
  output logic [2:0]                      rsp_len,
  input  logic [2:0]                      rsp_raddr,
  output logic [7:0]                      rsp_rdata
);
  localparam int LW   = $clog2(MSG_MAX + 1);
  localparam int CMAX = CHUNK + 3;
  localparam int CW   = $clog2(CMAX + 1);

  asm_state_t    state;
  logic          start_ok, take, in_eval, fire;
  logic [7:0]    f_cmd, f_cnt_field;
  logic [CW-1:0] f_nbytes;
  logic [7:0]    f_stage [CHUNK];
  logic [CW-1:0] j_plen;
  logic          j_reject, j_discard, j_commit, j_deliver;
  logic [LW-1:0] j_base, j_new_len;
  logic [LW-1:0] held_len;
  logic [7:0]    store [MSG_MAX];
  logic          q_match, q_short, q_bad;

  // Named internal events
  assign in_eval  = (state == AS_EVAL);
  assign fire     = (state == AS_DELIV);
  assign busy     = in_eval || fire;
  assign start_ok = bus_start && (state == AS_IDLE || state == AS_RX);
  assign take     = (state == AS_RX) && bus_valid && !bus_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= AS_IDLE;
    end else begin
      case (state)
        AS_IDLE:  if (start_ok) state <= AS_RX;
        AS_RX:    if (!start_ok && bus_stop) state <= AS_EVAL;
        AS_EVAL:  state <= j_deliver ? AS_DELIV : AS_IDLE;
        default:  state <= AS_IDLE;
      endcase
    end
  end

  ssif_rx_framer #(.CHUNK(CHUNK), .CW(CW)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (start_ok),
    .take      (take),
    .din       (bus_data),
    .cmd       (f_cmd),
    .cnt_field (f_cnt_field),
    .nbytes    (f_nbytes),
    .stage     (f_stage)
  );

  ssif_frag_judge #(.MSG_MAX(MSG_MAX), .CHUNK(CHUNK), .LW(LW), .CW(CW)) u_judge (
    .cmd       (f_cmd),
    .cnt_field (f_cnt_field),
    .nbytes    (f_nbytes),
    .held_len  (held_len),
    .plen      (j_plen),
    .reject    (j_reject),
    .discard   (j_discard),
    .commit    (j_commit),
    .deliver   (j_deliver),
    .base      (j_base),
    .new_len   (j_new_len)
  );

  // Held length of the request being built
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_len <= '0;
    end else if (in_eval) begin
      if (j_discard)     held_len <= '0;
      else if (j_commit) held_len <= j_new_len;
    end
  end

  // Message store: a whole chunk lands in one cycle, only once judged good
  always_ff @(posedge clk) begin
    if (in_eval && j_commit) begin
      for (int i = 0; i < CHUNK; i++) begin
        if (i < int'(j_plen)) store[LW'(int'(j_base) + i)] <= f_stage[i];
      end
    end
  end

  assign msg_rdata = (int'(msg_raddr) < MSG_MAX) ? store[msg_raddr] : 8'h00;

  // Capability query detection on the committed message
  assign q_match = (store[0] == QRY_B0) && (store[1] == QRY_B1);
  assign q_short = int'(held_len) < 3;
  assign q_bad   = store[2][3:0] != 4'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_pulse <= 1'b0;
      msg_ready <= 1'b0;
      msg_len   <= '0;
    end else begin
      err_pulse <= in_eval && j_reject;
      msg_ready <= fire && !q_match;
      if (fire && !q_match) msg_len <= held_len;
    end
  end

  ssif_cap_responder #(.MSG_MAX(MSG_MAX)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire),
    .is_query  (q_match),
    .too_short (q_short),
    .bad_field (q_bad),
    .rsp_raddr (rsp_raddr),
    .rsp_clear (rsp_clear),
    .rsp_len   (rsp_len),
    .rsp_rdata (rsp_rdata)
  );

  // Assertions
  p_one_outcome_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !(err_pulse && msg_ready));

  p_ready_single_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |=> !msg_ready);

  p_err_single_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  p_err_after_busy_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(busy));

  p_ready_after_busy_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |-> $past(busy));

  p_ready_clears_rsp_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |-> (rsp_clear && rsp_len == 3'd0));

  p_ready_nonempty_r1 : assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |-> (msg_len != '0));

  p_reject_keeps_held_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (in_eval && j_reject && !j_discard) |=> $stable(held_len));

  p_discard_empties_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (in_eval && j_discard) |=> (held_len == '0));

  p_bus_ignored_busy_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(state == AS_RX));

endmodule

// File: tb/test_ssif_req_assembler.sv
`timescale 1ns/1ps
module test_ssif_req_assembler;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_start = 1'b0, bus_valid = 1'b0, bus_stop = 1'b0;
  logic [7:0] bus_data = 8'h00;
  logic       busy, err_pulse, msg_ready, rsp_clear;
  logic [7:0] msg_len, msg_rdata, rsp_rdata;
  logic [7:0] msg_raddr = 8'h00;
  logic [2:0] rsp_len;
  logic [2:0] rsp_raddr = 3'd0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ssif_req_assembler i_ssif_req_assembler (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_valid(bus_valid),
    .bus_data(bus_data), .bus_stop(bus_stop), .busy(busy), .err_pulse(err_pulse),
    .msg_ready(msg_ready), .msg_len(msg_len), .msg_raddr(msg_raddr),
    .msg_rdata(msg_rdata), .rsp_clear(rsp_clear), .rsp_len(rsp_len),
    .rsp_raddr(rsp_raddr), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         ph = 0;
  int         held = 0;
  int         mstore [256];
  logic [7:0] rxq [$];
  bit         m_rej, m_send;
  bit         e_err = 0, e_rdy = 0, e_clr = 0;
  int         e_len = 0, e_rlen = 0;

  task automatic model_judge();
    int n, p, c;
    bit fb;
    n = rxq.size();
    m_rej = 0; m_send = 0;
    if (n == 0) return;
    c  = rxq[0];
    p  = (n >= 2) ? n - 2 : 0;
    fb = (n >= 2) && ((rxq[1] != p) || (rxq[1] > 32));
    if (c == 2 || c == 6) begin
      m_rej = fb || (p < 2);
      if (!m_rej) begin
        for (int k = 0; k < p; k++) mstore[k] = rxq[k + 2];
        held = p;
        m_send = (c == 2);
      end
    end else if (c == 7 || c == 8) begin
      m_rej = fb || (held == 0) || (held + p > 255);
      if (!fb && held != 0 && held + p > 255) held = 0;
      if (!m_rej) begin
        for (int k = 0; k < p; k++) mstore[held + k] = rxq[k + 2];
        held = held + p;
        m_send = (c == 8) || (p < 32);
      end
    end else begin
      m_rej = fb;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; held = 0; e_err = 0; e_rdy = 0; e_clr = 0; e_len = 0; e_rlen = 0;
    end else begin
      e_err = 0; e_rdy = 0; e_clr = 0;
      case (ph)
        0, 1: begin
          if (bus_start) begin
            ph = 1;
            rxq.delete();
          end else if (ph == 1 && bus_valid) begin
            rxq.push_back(bus_data);
          end else if (ph == 1 && bus_stop) begin
            model_judge();
            ph = 2;
          end
        end
        2: begin
          e_err = m_rej;
          ph = m_send ? 3 : 0;
        end
        default: begin
          ph = 0;
          e_clr = 1;
          if (mstore[0] == 'h18 && mstore[1] == 'h57) begin
            e_rlen = (held < 3) ? 3 : (((mstore[2] & 15) != 0) ? 3 : 7);
          end else begin
            e_rdy = 1; e_len = held; e_rlen = 0;
          end
        end
      endcase
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  int seen_err = 0, seen_rdy = 0, seen_len = 0, seen_clr = 0, seen_busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (ph == 2 || ph == 3), "R10 busy vs model", int'(busy), int'(ph == 2 || ph == 3));
      chk(err_pulse == e_err, "R9 err_pulse vs model", int'(err_pulse), int'(e_err));
      chk(msg_ready == e_rdy, "R1 msg_ready vs model", int'(msg_ready), int'(e_rdy));
      chk(rsp_clear == e_clr, "R8 rsp_clear vs model", int'(rsp_clear), int'(e_clr));
      chk(int'(rsp_len) == e_rlen, "R7 rsp_len vs model", int'(rsp_len), e_rlen);
      if (e_rdy) chk(int'(msg_len) == e_len, "R1 msg_len vs model", int'(msg_len), e_len);
      if (err_pulse) seen_err++;
      if (msg_ready) begin seen_rdy++; seen_len = int'(msg_len); end
      if (rsp_clear) seen_clr++;
      if (busy) seen_busy++;
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0] tx [$];

  task automatic mk(input int c, input int p, input int cf, input int v);
    tx.delete();
    tx.push_back(8'(c));
    if (cf >= 0) tx.push_back(8'(cf));
    for (int k = 0; k < p; k++) tx.push_back(8'(v + k));
  endtask

  task automatic run_write(input int ee, input int er, input int el, input string tag,
                           input bit hammer);
    seen_err = 0; seen_rdy = 0; seen_clr = 0; seen_busy = 0;
    @(negedge clk) bus_start = 1'b1;
    @(negedge clk) bus_start = 1'b0;
    foreach (tx[k]) begin
      bus_valid = 1'b1; bus_data = tx[k];
      @(negedge clk);
    end
    bus_valid = 1'b0;
    bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
    if (hammer) begin
      bus_start = 1'b1;
      @(negedge clk) bus_start = 1'b0;
      bus_valid = 1'b1; bus_data = 8'h02;
      @(negedge clk) bus_data = 8'h01;
      @(negedge clk) bus_data = 8'h55;
      @(negedge clk) bus_valid = 1'b0; bus_stop = 1'b1;
      @(negedge clk) bus_stop = 1'b0;
    end
    repeat (5) @(negedge clk);
    chk(seen_err == ee, {tag, " error pulses"}, seen_err, ee);
    chk(seen_rdy == er, {tag, " ready pulses"}, seen_rdy, er);
    if (er != 0) chk(seen_len == el, {tag, " length"}, seen_len, el);
  endtask

  task automatic rd_msg(input int a, input int exp, input string tag);
    @(negedge clk) msg_raddr = 8'(a);
    #1 chk(int'(msg_rdata) == exp, tag, int'(msg_rdata), exp);
  endtask

  task automatic rd_rsp(input int a, input int exp, input string tag);
    @(negedge clk) rsp_raddr = 3'(a);
    #1 chk(int'(rsp_rdata) == exp, tag, int'(rsp_rdata), exp);
  endtask

  task automatic fill_224();
    mk(6, 32, 32, 0); run_write(0, 0, 0, "R6 start 32", 0);
    for (int b = 1; b < 7; b++) begin
      mk(7, 32, 32, b * 32); run_write(0, 0, 0, "R6 full middle holds", 0);
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);
    chk(err_pulse == 1'b0, "R9 reset err", int'(err_pulse), 0);
    chk(msg_ready == 1'b0, "R1 reset ready", int'(msg_ready), 0);
    chk(rsp_len == 3'd0, "R8 reset rsp_len", int'(rsp_len), 0);

    // R4: fragments with nothing held
    mk(7, 3, 3, 1); run_write(1, 0, 0, "R4 middle when empty", 0);
    mk(8, 3, 3, 1); run_write(1, 0, 0, "R4 final when empty", 0);

    // R1: single-part request
    mk(2, 5, 5, 'h40); run_write(0, 1, 5, "R1 single request", 0);
    chk(seen_busy == 2, "R10 busy cycles on delivery", seen_busy, 2);
    for (int k = 0; k < 5; k++) rd_msg(k, 'h40 + k, "R1 stored byte");

    // R2: framing
    mk(2, 5, 6, 'h90);  run_write(1, 0, 0, "R2 count mismatch", 0);
    chk(seen_busy == 1, "R10 busy cycles on rejection", seen_busy, 1);
    mk(2, 33, 33, 'h90); run_write(1, 0, 0, "R2 count over 32", 0);
    rd_msg(0, 'h40, "R9 store untouched after reject");

    // R3: too short
    mk(2, 1, 1, 'h90);  run_write(1, 0, 0, "R3 single with one byte", 0);
    mk(6, 0, -1, 0);    run_write(1, 0, 0, "R3 start with code only", 0);
    rd_msg(1, 'h41, "R9 store untouched after short");

    // R6: multi-part ended by final fragment
    mk(6, 32, 32, 0);   run_write(0, 0, 0, "R6 start", 0);
    mk(7, 32, 32, 32);  run_write(0, 0, 0, "R6 full middle", 0);
    mk(8, 5, 5, 64);    run_write(0, 1, 69, "R6 final", 0);
    rd_msg(0, 0, "R3 start at offset 0");
    rd_msg(40, 40, "R6 middle placed");
    rd_msg(68, 68, "R6 final placed");

    // R6: short middle and empty middle end the request
    mk(6, 10, 10, 'hA0); run_write(0, 0, 0, "R6 start 10", 0);
    mk(7, 4, 4, 'hB0);   run_write(0, 1, 14, "R6 short middle ends", 0);
    rd_msg(10, 'hB0, "R6 short middle placed");
    mk(6, 10, 10, 'hA0); run_write(0, 0, 0, "R6 start 10 again", 0);
    mk(7, 0, -1, 0);     run_write(0, 1, 10, "R6 empty middle ends", 0);

    // R5: exact fit and overflow
    fill_224();
    mk(8, 31, 31, 224);  run_write(0, 1, 255, "R5 total 255 accepted", 0);
    rd_msg(254, 254, "R5 last byte stored");
    fill_224();
    mk(7, 32, 32, 0);    run_write(1, 0, 0, "R5 overflow rejected", 0);
    mk(8, 1, 1, 0);      run_write(1, 0, 0, "R5 discarded so next rejected", 0);

    // R7: capability query
    tx = '{8'h02, 8'h03, 8'h18, 8'h57, 8'h00};
    run_write(0, 0, 0, "R7 query good", 0);
    chk(seen_clr == 1, "R8 clear on local answer", seen_clr, 1);
    chk(int'(rsp_len) == 7, "R7 full reply length", int'(rsp_len), 7);
    rd_rsp(0, 'h1C, "R7 reply byte 0");
    rd_rsp(1, 'h57, "R7 reply byte 1");
    rd_rsp(2, 'h00, "R7 reply byte 2");
    rd_rsp(3, 'h00, "R7 reply byte 3");
    rd_rsp(4, 'h80, "R7 reply byte 4");
    rd_rsp(5, 'hFF, "R7 reply byte 5");
    rd_rsp(6, 'hFF, "R7 reply byte 6");
    tx = '{8'h02, 8'h02, 8'h18, 8'h57};
    run_write(0, 0, 0, "R7 query short", 0);
    chk(int'(rsp_len) == 3, "R7 short reply length", int'(rsp_len), 3);
    rd_rsp(2, 'hC7, "R7 short completion code");
    tx = '{8'h02, 8'h03, 8'h18, 8'h57, 8'h05};
    run_write(0, 0, 0, "R7 query bad field", 0);
    chk(int'(rsp_len) == 3, "R7 bad field reply length", int'(rsp_len), 3);
    rd_rsp(2, 'hCC, "R7 bad field completion code");

    // R8: ordinary delivery drops the reply
    mk(2, 4, 4, 'h10); run_write(0, 1, 4, "R8 ordinary after query", 0);
    chk(seen_clr == 1, "R8 clear pulse", seen_clr, 1);
    chk(int'(rsp_len) == 0, "R8 reply length zero", int'(rsp_len), 0);

    // R11: other codes
    tx = '{8'h03};                      run_write(0, 0, 0, "R11 code only", 0);
    tx = '{8'h09, 8'h02, 8'h01, 8'h02}; run_write(0, 0, 0, "R11 other code framed", 0);
    rd_msg(0, 'h10, "R11 store unchanged");
    tx = '{8'h55, 8'h03, 8'h01};        run_write(1, 0, 0, "R2 other code bad count", 0);

    // R10: bus activity while busy is ignored
    mk(2, 3, 3, 'h70); run_write(0, 1, 3, "R10 start while busy ignored", 1);
    rd_msg(0, 'h70, "R10 store holds first write");
    rd_msg(2, 'h72, "R10 store not overwritten");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule